// File: doc/BRIEF.md
# Per-Flow Packet and Byte Counter Updater

This block keeps a packet counter and a byte counter for each flow record in a local counter store. Every packet arrives as one update carrying a 16-bit statistics index and the IP length of the packet. The block adds one to the record's packet counter. It adds the full Ethernet frame length, which is the IP length plus 18 header bytes, to the record's byte counter.

Each update is done as a read, a local add and a write-back. No atomic memory command is used. The read-to-write path is two cycles deep. An update that targets a record whose previous update has not yet been written takes the pending sum directly from the pipeline, so updates to the same record can arrive on consecutive cycles and no count is lost.

A separate read port returns a counter pair one cycle after the request. After reset the block zeroes every record in turn and holds its update input not ready until this clearing pass has finished.

Top module: `flow_stat_counter`

## Requirements
- R1: After reset `upd_ready_o` is low while the block clears the records, one record per cycle. It rises after exactly DEPTH (64) rising edges and then stays high. Every record then reads packet count 0 and byte count 0.
- R2: An update is taken on a rising edge where both `upd_valid_i` and `upd_ready_o` are high, at most one per edge. An update offered while `upd_ready_o` is low, or a cycle with `upd_valid_i` low, changes no counter.
- R3: The record is selected by the low ADDR_W (6) bits of the 16-bit index. The upper bits are ignored by both the update and the read port.
- R4: Each accepted update increases the record's packet counter by exactly one.
- R5: Each accepted update increases the record's 64-bit byte counter by `upd_ip_len_i` + 18.
- R6: An update taken at rising edge N is written to the store at edge N+2. A read sampled at edge N+1 still returns the old values.
- R7: Updates to the same record on consecutive edges, or interleaved with other records, all count, because in-flight sums are forwarded.
- R8: `rd_req_i` sampled high at an edge makes `rd_valid_o` high for the following cycle, with `rd_pkt_o` and `rd_byte_o` holding the record selected by `rd_idx_i`. With no request, `rd_valid_o` is low.
- R9: A read sampled at the same edge as a write to the same record returns the newly written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_valid_i | input | 1 | Update offered |
| upd_ready_o | output | 1 | Update can be taken (clearing pass finished) |
| upd_idx_i | input | 16 | Statistics index of the update |
| upd_ip_len_i | input | 16 | IP length of the packet in bytes |
| rd_req_i | input | 1 | Software read request |
| rd_idx_i | input | 16 | Statistics index to read |
| rd_valid_o | output | 1 | Read data valid |
| rd_pkt_o | output | 32 | Packet counter of the read record |
| rd_byte_o | output | 64 | Byte counter of the read record |

## Verification
Two functions can land in the same cycle: the write-back of an update and a software read of the same record. The bench provokes this by offering an update and then holding a read request on the same index across the next two edges. The first read must return the old pair. The second read coincides with the write and must return the incremented pair. The forwarding path meets a second kind of collision, which the bench provokes with back-to-back and interleaved updates. It judges those updates against a reference model after the pipeline drains, including a long randomized stream that folds aliased indices onto a few records.

// File: rtl/flow_stat_pkg.sv
package flow_stat_pkg;
  parameter int unsigned IDX_W  = 16;
  parameter int unsigned LEN_W  = 16;
  parameter int unsigned PKT_W  = 32;
  parameter int unsigned BYTE_W = 64;

  typedef struct packed {
    logic [BYTE_W-1:0] bytes;
    logic [PKT_W-1:0]  pkts;
  } ctr_rec_t;
endpackage

// File: rtl/flow_stat_init.sv
module flow_stat_init #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              clr_we_o,
  output logic [ADDR_W-1:0] clr_addr_o,
  output logic              done_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic              busy_q;
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == ADDR_W'(DEPTH - 1)) busy_q <= 1'b0;
    end
  end

  assign clr_we_o   = busy_q;
  assign clr_addr_o = cnt_q;
  assign done_o     = !busy_q;
endmodule

// File: rtl/flow_stat_mem.sv
module flow_stat_mem
  import flow_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  ctr_rec_t          wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output ctr_rec_t          rdata_o,
  input  logic              sw_req_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  output logic              sw_valid_o,
  output ctr_rec_t          sw_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  ctr_rec_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // software port: same-edge write to the same record wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_valid_o <= 1'b0;
      sw_data_o  <= '0;
    end else begin
      sw_valid_o <= sw_req_i;
      if (sw_req_i) sw_data_o <= (we_i && waddr_i == sw_addr_i) ? wdata_i : mem_q[sw_addr_i];
    end
  end
endmodule

// File: rtl/flow_stat_rmw.sv
module flow_stat_rmw
  import flow_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned HDR_BYTES = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  ctr_rec_t          rdata_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output ctr_rec_t          wdata_o
);
  logic              s1_v_q, s2_v_q;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q;
  logic [LEN_W-1:0]  s1_len_q;
  ctr_rec_t          s2_rec_q;
  ctr_rec_t          base, sum;

  always_comb begin
    // forward the unwritten sum of the previous update
    base      = (s2_v_q && s2_addr_q == s1_addr_q) ? s2_rec_q : rdata_i;
    sum.pkts  = base.pkts + 1'b1;
    sum.bytes = base.bytes + BYTE_W'(s1_len_q) + BYTE_W'(HDR_BYTES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q    <= 1'b0;
      s2_v_q    <= 1'b0;
      s1_addr_q <= '0;
      s2_addr_q <= '0;
      s1_len_q  <= '0;
      s2_rec_q  <= '0;
    end else begin
      s1_v_q <= acc_i;
      s2_v_q <= s1_v_q;
      if (acc_i) begin
        s1_addr_q <= addr_i;
        s1_len_q  <= len_i;
      end
      if (s1_v_q) begin
        s2_addr_q <= s1_addr_q;
        s2_rec_q  <= sum;
      end
    end
  end

  assign raddr_o = s1_addr_q;
  assign we_o    = s2_v_q;
  assign waddr_o = s2_addr_q;
  assign wdata_o = s2_rec_q;
endmodule

// File: rtl/flow_stat_counter.sv
module flow_stat_counter
  import flow_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned HDR_BYTES = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  output logic              upd_ready_o,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [LEN_W-1:0]  upd_ip_len_i,
  input  logic              rd_req_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [PKT_W-1:0]  rd_pkt_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  logic              init_done, clr_we, pipe_we, mem_we, accept;
  logic [ADDR_W-1:0] clr_addr, pipe_waddr, pipe_raddr, mem_waddr;
  ctr_rec_t          pipe_wdata, mem_wdata, pipe_rdata, sw_rec;
  logic              idx_hi_unused;

  assign idx_hi_unused = ^{upd_idx_i[IDX_W-1:ADDR_W], rd_idx_i[IDX_W-1:ADDR_W]};

  assign upd_ready_o = init_done;
  assign accept      = upd_valid_i && init_done;

  flow_stat_init #(.ADDR_W(ADDR_W)) i_init (
    .clk_i, .rst_ni,
    .clr_we_o   (clr_we),
    .clr_addr_o (clr_addr),
    .done_o     (init_done)
  );

  flow_stat_rmw #(.ADDR_W(ADDR_W), .HDR_BYTES(HDR_BYTES)) i_rmw (
    .clk_i, .rst_ni,
    .acc_i   (accept),
    .addr_i  (upd_idx_i[ADDR_W-1:0]),
    .len_i   (upd_ip_len_i),
    .raddr_o (pipe_raddr),
    .rdata_i (pipe_rdata),
    .we_o    (pipe_we),
    .waddr_o (pipe_waddr),
    .wdata_o (pipe_wdata)
  );

  assign mem_we    = clr_we || pipe_we;
  assign mem_waddr = clr_we ? clr_addr : pipe_waddr;
  assign mem_wdata = clr_we ? '0 : pipe_wdata;

  flow_stat_mem #(.ADDR_W(ADDR_W)) i_mem (
    .clk_i, .rst_ni,
    .we_i       (mem_we),
    .waddr_i    (mem_waddr),
    .wdata_i    (mem_wdata),
    .raddr_i    (pipe_raddr),
    .rdata_o    (pipe_rdata),
    .sw_req_i   (rd_req_i),
    .sw_addr_i  (rd_idx_i[ADDR_W-1:0]),
    .sw_valid_o (rd_valid_o),
    .sw_data_o  (sw_rec)
  );

  assign rd_pkt_o  = sw_rec.pkts;
  assign rd_byte_o = sw_rec.bytes;
endmodule

// File: rtl/flow_stat_counter_chk.sv
module flow_stat_counter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic upd_valid_i,
  input logic upd_ready_o,
  input logic rd_req_i,
  input logic rd_valid_o,
  input logic pipe_we
);
  // R1
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_ready_o |=> upd_ready_o);
  // R2
  init_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_ready_o |-> !pipe_we);
  // R6
  write_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_ready_o) |-> ##2 pipe_we);
  // R8
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);
  // R8
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);
endmodule

bind flow_stat_counter flow_stat_counter_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .upd_ready_o (upd_ready_o),
  .rd_req_i    (rd_req_i),
  .rd_valid_o  (rd_valid_o),
  .pipe_we     (pipe_we)
);

// File: tb/test_flow_stat_counter.sv
`timescale 1ns/1ps
module test_flow_stat_counter;
  localparam int DEPTH = 64;
  localparam int HDR   = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [15:0] upd_idx = '0;
  logic [15:0] upd_len = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_idx = '0;
  logic        rd_valid;
  logic [31:0] rd_pkt;
  logic [63:0] rd_byte;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_pkt  [DEPTH];
  logic [63:0] exp_byte [DEPTH];

  always #4 clk = ~clk;

  flow_stat_counter i_flow_stat_counter (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_valid_i(upd_valid), .upd_ready_o(upd_ready),
    .upd_idx_i(upd_idx), .upd_ip_len_i(upd_len),
    .rd_req_i(rd_req), .rd_idx_i(rd_idx),
    .rd_valid_o(rd_valid), .rd_pkt_o(rd_pkt), .rd_byte_o(rd_byte)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic drive(logic [15:0] idx, logic [15:0] len);
    upd_valid = 1'b1; upd_idx = idx; upd_len = len;
    if (upd_ready) begin
      exp_pkt[idx[5:0]]  += 1;
      exp_byte[idx[5:0]] += 64'(len) + HDR;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    upd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(string tag, logic [15:0] idx, logic [31:0] ep, logic [63:0] eb);
    rd_req = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_req = 1'b0;
    check({tag, " R8 valid"}, 64'(rd_valid), 64'd1);
    check({tag, " pkts"}, 64'(rd_pkt), 64'(ep));
    check({tag, " bytes"}, rd_byte, eb);
  endtask

  task automatic t_reset();
    int n = 0;
    check("R1 ready low after reset", 64'(upd_ready), 64'd0);
    check("R8 no read valid after reset", 64'(rd_valid), 64'd0);
    while (!upd_ready && n < 1000) begin
      upd_valid = 1'b1; upd_idx = 16'h0003; upd_len = 16'd500;
      @(posedge clk); n++;
      @(negedge clk);
    end
    upd_valid = 1'b0;
    check("R1 clearing length", 64'(n), 64'(DEPTH));
    idle(3);
    read_chk("R2 offer during clearing ignored", 16'h0003, 32'd0, 64'd0);
    read_chk("R1 last record cleared", 16'h003f, 32'd0, 64'd0);
    idle(1);
    check("R8 valid drops without request", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_single();
    drive(16'h0005, 16'd46);
    idle(3);
    read_chk("R4 R5 single update", 16'h0005, exp_pkt[5], exp_byte[5]);
    check("R5 frame length added", exp_byte[5], 64'd64);
  endtask

  task automatic t_b2b();
    drive(16'h0007, 16'd20);
    drive(16'h0007, 16'd1500);
    drive(16'h0007, 16'd0);
    drive(16'h0007, 16'd100);
    idle(3);
    read_chk("R7 back-to-back same record", 16'h0007, 32'd4, 64'd1692);
    drive(16'h0008, 16'd10);
    drive(16'h0007, 16'd30);
    drive(16'h0008, 16'd40);
    drive(16'h0007, 16'd50);
    idle(3);
    read_chk("R7 interleaved record 7", 16'h0007, exp_pkt[7], exp_byte[7]);
    read_chk("R7 interleaved record 8", 16'h0008, exp_pkt[8], exp_byte[8]);
  endtask

  task automatic t_alias();
    drive(16'h0145, 16'd100);
    drive(16'hff05, 16'd200);
    idle(3);
    read_chk("R3 upper index bits ignored", 16'h8005, exp_pkt[5], exp_byte[5]);
    read_chk("R3 neighbour untouched", 16'h0006, 32'd0, 64'd0);
  endtask

  task automatic t_collide();
    logic [31:0] op;
    logic [63:0] ob;
    op = exp_pkt[9]; ob = exp_byte[9];
    drive(16'h0009, 16'd100);          // taken at edge N
    upd_valid = 1'b0;
    rd_req = 1'b1; rd_idx = 16'h0009;  // sampled at N+1
    @(negedge clk);
    check("R6 read at N+1 old pkts", 64'(rd_pkt), 64'(op));
    check("R6 read at N+1 old bytes", rd_byte, ob);
    @(negedge clk);                    // sampled at N+2 with the write
    rd_req = 1'b0;
    check("R9 collide pkts", 64'(rd_pkt), 64'(exp_pkt[9]));
    check("R9 collide bytes", rd_byte, exp_byte[9]);
    idle(2);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) != 0)
        drive(16'($urandom) & 16'hff03, 16'($urandom_range(0, 1600)));
      else
        idle(1);
    end
    idle(3);
    for (int r = 0; r < DEPTH; r++)
      read_chk("R2 R7 stream", 16'(r), exp_pkt[r], exp_byte[r]);
  endtask

  initial begin
    for (int r = 0; r < DEPTH; r++) begin
      exp_pkt[r] = '0; exp_byte[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_b2b();
    t_alias();
    t_collide();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule